// File: doc/BRIEF.md
# Boot-Mode Root Clock Selector

This block sets up the two root timing references of a chip from three strap pins that are read while reset is held. One reference is the system clock and the other is a slow real-time tick. The block receives a single main reference clock, a strobe that is already synchronised to that clock and that marks edges of an external 32.768 kHz source, and the three strap pins. It drives two clock-enable strobes, and both are qualified against the main reference clock. Downstream logic runs on the reference clock and advances only in the cycles where the matching enable is high.

Strap bit 1 sets the system rate. When it is clear, the system enable is high in every cycle. When it is set, the system enable is high in one cycle out of two. Strap bit 2 sets where the slow tick comes from. When it is clear, the tick follows the external 32.768 kHz strobe. When it is set, the tick is made by dividing the main reference, by 1024 if bit 1 is clear or by 2048 if bit 1 is set. The 2048 path is a divide-by-2 stage feeding a divide-by-1024 stage. Strap bit 0 only tells the board which kind of oscillator is fitted, crystal or external. It has no effect on this logic.

The straps are captured on every clock edge while reset is low. After reset is released they stay frozen. All divider counters start from zero, so the spacing from reset release to the first strobe is exact.

Top module: `boot_clk_root_sel`

## Requirements
- R1: The strap value sampled at the last clock edge with `rst_n` low sets the behaviour. Changes on `boot_mode` after release have no effect on either output until the next reset.
- R2: With strap bit 1 (`boot_mode[1]`) clear, `sys_en` is high after every rising edge from the first edge with `rst_n` high onward.
- R3: With strap bit 1 set, `sys_en` is high only after the 2nd, 4th, 6th, … rising edges counted from release, and it is never high for two cycles in a row.
- R4: With strap bit 2 (`boot_mode[2]`) clear, `rtc_en` after rising edge k (k ≥ 1 since release) equals the value `slow_in_en` had at edge k. This holds for either value of bit 1.
- R5: With strap bits 2:1 equal to 2'b10, `rtc_en` is a one-cycle pulse after rising edges 1024, 2048, … counted from release, and low otherwise.
- R6: With strap bits 2:1 equal to 2'b11, `rtc_en` is a one-cycle pulse after rising edges 2048, 4096, … counted from release, and low otherwise.
- R7: Strap bit 0 (`boot_mode[0]`) has no effect on either output.
- R8: While `rst_n` is low, both outputs are low after every clock edge, and `slow_in_en` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Main reference clock; every register of the block runs on it |
| rst_n | input | 1 | Synchronous active-low reset; the straps are captured while it is low |
| boot_mode | input | 3 | Strap pins: bit 2 selects a divided slow tick, bit 1 selects half-rate system and the doubled slow divide, bit 0 is the oscillator kind |
| slow_in_en | input | 1 | One-cycle strobe from the external 32.768 kHz source, already synchronised to `clk_ref` |
| sys_en | output | 1 | System clock enable |
| rtc_en | output | 1 | Slow real-time tick enable |

## Verification
The bench runs all eight strap codes. In each run it scrambles the straps a few cycles after release. A design that kept sampling the pins would then change rate partway through the run. The first strobe is checked at its exact edge: 1, 2, 1024 or 2048 cycles after release. A counter that started at one, or a 2048 chain that took its advance from a registered divide-by-2 output, would show up as a one-cycle shift or a missing pulse. The pin-sourced tick is driven with an irregular strobe, also during reset, so a design that dropped the one-cycle latency or let the strobe through while in reset would give a mismatch against the cycle model.

// File: rtl/boot_clk_pkg.sv
// Package: shared types and decode for the boot-mode root clock selector.
// Assumes the three strap pins are bit-ordered {rtc_divided, sys_half, osc_ext}.
package boot_clk_pkg;

    // Strap word as captured during reset; bit order matches the pins.
    typedef struct packed {
        logic rtc_divided;  // bit 2: slow tick made from the main reference
        logic sys_half;     // bit 1: system runs at half rate, slow divide doubles
        logic osc_ext;      // bit 0: oscillator kind, no logic effect
    } boot_mode_t;

    // Where the slow tick comes from.
    typedef enum logic [1:0] {
        RTC_FROM_PIN   = 2'd0,
        RTC_DIV_BASE   = 2'd1,
        RTC_DIV_DOUBLE = 2'd2
    } rtc_src_e;

    // Map a captured strap word to the slow tick source.
    function automatic rtc_src_e rtc_source(input boot_mode_t m);
        if (!m.rtc_divided)
            return RTC_FROM_PIN;
        else if (m.sys_half)
            return RTC_DIV_DOUBLE;
        else
            return RTC_DIV_BASE;
    endfunction

endpackage

// File: rtl/boot_clk_mode_latch.sv
// Module: captures the strap pins while reset is low and holds them after.
// Assumes rst_n is synchronous to clk_ref and stays low for at least one edge.
module boot_clk_mode_latch
    import boot_clk_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input  logic              clk_ref,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_pins,
    output boot_mode_t        mode_q
);

    // Follow the pins during reset; freeze them once reset is released.
    always_ff @(posedge clk_ref) begin
        if (!rst_n)
            mode_q <= boot_mode_t'(mode_pins);
    end

    // R1: the captured straps never move while running
    p_mode_hold_r1: assert property (@(posedge clk_ref) disable iff (!rst_n)
        $past(rst_n) |-> $stable(mode_q));

endmodule

// File: rtl/boot_clk_div.sv
// Module: fixed divide-by-DIV counter. It advances on 'adv' and flags the
// cycle in which it wraps. Assumes DIV >= 1. The counter starts at zero on
// reset, so the first wrap comes after exactly DIV advances.
module boot_clk_div #(
    parameter int DIV = 2
) (
    input  logic clk_ref,
    input  logic rst_n,
    input  logic adv,
    output logic wrap
);

    generate
        if (DIV == 1) begin : g_pass
            // A divide of one wraps on every advance.
            assign wrap = adv;
        end else begin : g_count
            localparam int CW = $clog2(DIV);
            localparam logic [CW-1:0] LAST = CW'(DIV - 1);

            logic [CW-1:0] cnt;

            // Wrap flag: last count and an advance in this cycle.
            assign wrap = adv && (cnt == LAST);

            // Count advances and return to zero on wrap.
            always_ff @(posedge clk_ref) begin
                if (!rst_n)
                    cnt <= '0;
                else if (wrap)
                    cnt <= '0;
                else if (adv)
                    cnt <= cnt + 1'b1;
            end

            // R3: two wraps are never back to back
            p_wrap_spaced_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
                wrap |=> !wrap);
        end
    endgenerate

endmodule

// File: rtl/boot_clk_out_sel.sv
// Module: selects and registers the two enable strobes.
// Assumes the divider wrap inputs are single-cycle flags on clk_ref and that
// slow_pin_en is already synchronised to clk_ref.
module boot_clk_out_sel
    import boot_clk_pkg::*;
(
    input  logic       clk_ref,
    input  logic       rst_n,
    input  boot_mode_t mode_q,
    input  logic       half_wrap,
    input  logic       slow_div_wrap,
    input  logic       slow_pin_en,
    output logic       sys_en,
    output logic       rtc_en
);

    rtc_src_e src;
    logic     rtc_next;
    logic     osc_kind_unused;

    assign src             = rtc_source(mode_q);
    assign osc_kind_unused = mode_q.osc_ext;

    // Choose the slow tick source for the next cycle.
    always_comb begin
        unique case (src)
            RTC_FROM_PIN: rtc_next = slow_pin_en;
            default:      rtc_next = slow_div_wrap;
        endcase
    end

    // Register both strobes; both are quiet during reset.
    always_ff @(posedge clk_ref) begin
        if (!rst_n) begin
            sys_en <= 1'b0;
            rtc_en <= 1'b0;
        end else begin
            sys_en <= mode_q.sys_half ? half_wrap : 1'b1;
            rtc_en <= rtc_next;
        end
    end

    // R2: at full rate the system enable stays high once running
    p_sys_full_r2: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (!mode_q.sys_half && $past(rst_n)) |-> sys_en);

    // R3: at half rate the system enable is a single-cycle pulse
    p_sys_half_single_r3: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (mode_q.sys_half && sys_en) |=> !sys_en);

    // R4: the pin-sourced tick is the strobe delayed by one cycle
    p_rtc_pin_r4: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (src == RTC_FROM_PIN) |=> (rtc_en == $past(slow_pin_en)));

    // R5: a divided tick is a single-cycle pulse
    p_rtc_div_single_r5: assert property (@(posedge clk_ref) disable iff (!rst_n)
        (src != RTC_FROM_PIN && rtc_en) |=> !rtc_en);

    // R8: both strobes are low after a reset edge
    p_reset_quiet_r8: assert property (@(posedge clk_ref)
        !rst_n |=> (!sys_en && !rtc_en));

endmodule

// File: rtl/boot_clk_root_sel.sv
// Module: boot-mode root clock selector (top). It makes a system clock enable
// and a slow tick enable from straps captured in reset.
// Assumes a single reference clock domain; the 32.768 kHz strobe arrives
// already synchronised.
module boot_clk_root_sel
    import boot_clk_pkg::*;
#(
    parameter int SYS_PREDIV    = 2,
    parameter int SLOW_DIV_BASE = 1024
) (
    input  logic       clk_ref,
    input  logic       rst_n,
    input  logic [2:0] boot_mode,
    input  logic       slow_in_en,
    output logic       sys_en,
    output logic       rtc_en
);

    localparam int MODE_W = $bits(boot_mode_t);

    boot_mode_t mode_q;
    logic       half_wrap;
    logic       slow_adv;
    logic       slow_div_wrap;

    boot_clk_mode_latch #(.MODE_W(MODE_W)) u_latch (
        .clk_ref   (clk_ref),
        .rst_n     (rst_n),
        .mode_pins (boot_mode),
        .mode_q    (mode_q)
    );

    // Pre-divider: sets the half-rate system clock and heads the doubled slow chain.
    boot_clk_div #(.DIV(SYS_PREDIV)) u_prediv (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .adv     (1'b1),
        .wrap    (half_wrap)
    );

    // Slow divider advance: every cycle, or on each pre-divider wrap for the doubled divide.
    assign slow_adv = mode_q.sys_half ? half_wrap : 1'b1;

    boot_clk_div #(.DIV(SLOW_DIV_BASE)) u_slowdiv (
        .clk_ref (clk_ref),
        .rst_n   (rst_n),
        .adv     (slow_adv),
        .wrap    (slow_div_wrap)
    );

    boot_clk_out_sel u_sel (
        .clk_ref       (clk_ref),
        .rst_n         (rst_n),
        .mode_q        (mode_q),
        .half_wrap     (half_wrap),
        .slow_div_wrap (slow_div_wrap),
        .slow_pin_en   (slow_in_en),
        .sys_en        (sys_en),
        .rtc_en        (rtc_en)
    );

endmodule

// File: tb/boot_clk_root_sel_tb.sv
// Bench: a behavioural cycle model (edge count since release) compared on every clock.
module boot_clk_root_sel_tb;

    logic       clk_ref = 1'b0;
    logic       rst_n   = 1'b0;
    logic [2:0] boot_mode = 3'd0;
    logic       slow_in_en = 1'b0;
    logic       sys_en;
    logic       rtc_en;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    bit active = 1'b0;

    // Reference state
    int       k = 0;
    logic [2:0] mref = 3'd0;
    logic     slow_seen = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    always #2 clk_ref = ~clk_ref;

    boot_clk_root_sel u_dut (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .boot_mode  (boot_mode),
        .slow_in_en (slow_in_en),
        .sys_en     (sys_en),
        .rtc_en     (rtc_en)
    );

    // Model: count edges since release, remember the straps and the strobe.
    always @(posedge clk_ref) begin
        if (!rst_n) begin
            k    <= 0;
            mref <= boot_mode;
        end else begin
            k         <= k + 1;
            slow_seen <= slow_in_en;
        end
    end

    // Irregular external strobe, toggling also during reset.
    always @(negedge clk_ref) begin
        lfsr       = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        slow_in_en = (lfsr[1:0] == 2'b00);
    end

    task automatic check(input logic act, input logic exp, input string tag, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at edge %0d mode %b: actual %b expected %b",
                     tag, what, k, mref, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge.
    always @(negedge clk_ref) begin
        if (active) begin
            logic  e_sys, e_rtc;
            string t_sys, t_rtc;
            int    d;
            d     = mref[1] ? 2048 : 1024;
            e_sys = mref[1] ? (k >= 2 && k % 2 == 0) : (k >= 1);
            e_rtc = !mref[2] ? (k >= 1 && slow_seen) : (k >= 1 && k % d == 0);
            if (k == 0)                 t_sys = "R8";
            else if (k >= 4 && k < 40)  t_sys = "R1";
            else if (mref[0])           t_sys = "R7";
            else if (mref[1])           t_sys = "R3";
            else                        t_sys = "R2";
            if (k == 0)                 t_rtc = "R8";
            else if (!mref[2])          t_rtc = "R4";
            else if (mref[1])           t_rtc = "R6";
            else                        t_rtc = "R5";
            check(sys_en, e_sys, t_sys, "sys_en");
            check(rtc_en, e_rtc, t_rtc, "rtc_en");
        end
    end

    task automatic run_mode(input logic [2:0] m);
        rst_n     = 1'b0;
        boot_mode = m;
        repeat (6) @(negedge clk_ref);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_ref);
        boot_mode = ~m;  // R1: scramble the straps after release
        repeat (4200) @(negedge clk_ref);
    endtask

    initial begin
        @(negedge clk_ref);
        active = 1'b1;
        for (int m = 0; m < 8; m++) run_mode(3'(m));
        rst_n = 1'b0;
        repeat (3) @(negedge clk_ref);
        active = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk_ref);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule